// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register-mapped mailbox between a host processor and a management microcontroller. The host writes up to four payload words into a write buffer. It then writes a command word that holds a command code, a sub-command id, a payload size and an interrupt-on-completion flag. The controller gets a one-cycle doorbell pulse, the decoded command fields, the id of the host that sent the command and the payload words.

The controller can fill a read buffer of four words at any time. When it has finished the command it strobes `ctl_done` together with an error flag and an error code. This clears busy. If the command asked for it, the host also gets a one-cycle completion interrupt, which needs no clearing. A host that has no interrupt polls the status word until busy is clear and then reads the error bit.

The host port is a plain 32-bit register port. It is always ready, so it has no back-pressure. A request lasts exactly one cycle. Each read returns one cycle later, with `hst_rvalid` set for that one cycle. The controller-side strobes (`ctl_done`, `ctl_rb_we`) also last one cycle each and are never stalled.

Top module: `host_ctl_mailbox`

## Requirements
- R1: After reset, busy, error, error code, overrun, doorbell and interrupt are 0. Every write-buffer word and every read-buffer word is 0.
- R2: The command register is at offset 0x00. When it is written while busy is 0, busy is 1 from the next cycle and `ctl_doorbell` pulses for exactly that one cycle. The fields are presented from that cycle on: code = bits 7:0, interrupt-on-completion = bit 8, sub-command id = bits 15:12, payload size = bits 23:16. The sender's `hst_initiator` is also presented.
- R3: Busy stays 1 until a cycle in which `ctl_done` is high, and is 0 from the next cycle. That strobe captures `ctl_err` and `ctl_err_code`. An accepted command write clears the error bit and the error code.
- R4: The status word is at offset 0x04. Its layout is: bit 0 busy, bit 1 error, bits 7:4 the sub-command id of the last command, bits 15:8 the initiator id, bits 23:16 the error code. All other bits read 0.
- R5: A command write while busy is 1 is ignored and sets `ctl_overrun`. This flag stays set until reset. A write-buffer write while busy is 1 is also ignored.
- R6: `host_irq` pulses for one cycle, in the cycle after a `ctl_done` that ends a command whose interrupt-on-completion bit was 1. It never pulses otherwise.
- R7: A host word write to offset 0x80 + 4*i (i = 0..3) while not busy appears on `ctl_wbuf[32*i +: 32]` from the next cycle.
- R8: The controller writes read-buffer word i with `ctl_rb_we`. The host reads it at 0x90 + 4*i. With `hst_byte` = 1 the host gets byte lane `addr[1:0]` (lane k is bits 8k+7:8k), zero-extended in bits 7:0.
- R9: Host writes to the status word or to the read buffer have no effect. Reads of the command register, of the write buffer and of unmapped offsets return 0.
- R10: A read request gives `hst_rvalid` = 1 for exactly the next cycle. The data is the state as it stood before the clock edge that took the request.
- R11: A `ctl_done` while busy is 0 has no effect. It changes neither busy, error, error code nor `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access request, one cycle |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_byte | input | 1 | Read returns a single byte lane |
| hst_addr | input | ADDR_W | Byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_initiator | input | 8 | Id of the requesting host |
| hst_rvalid | output | 1 | Read data valid |
| hst_rdata | output | 32 | Read data |
| host_irq | output | 1 | Completion interrupt pulse |
| ctl_doorbell | output | 1 | New-command pulse to the controller |
| ctl_busy | output | 1 | Command outstanding |
| ctl_cmd_code | output | 8 | Command code |
| ctl_ioc | output | 1 | Interrupt-on-completion requested |
| ctl_sub | output | 4 | Sub-command id |
| ctl_size | output | 8 | Payload size |
| ctl_initiator | output | 8 | Initiator of the current command |
| ctl_wbuf | output | 32*WBUF_WORDS | Write buffer contents |
| ctl_done | input | 1 | Command completion strobe |
| ctl_err | input | 1 | Error flag, taken at the strobe |
| ctl_err_code | input | 8 | Error code, taken at the strobe |
| ctl_rb_we | input | 1 | Read-buffer word write |
| ctl_rb_idx | input | RB_IDX_W | Read-buffer word index |
| ctl_rb_data | input | 32 | Read-buffer word data |
| ctl_overrun | output | 1 | Sticky command-overrun flag |

## Verification
The command path is tried in four ways: an idle write, a write that lands while busy, a write in the very cycle of `ctl_done`, and a `ctl_done` with nothing outstanding. Together these separate a correct busy gate from one that samples busy after the edge. Commands are issued with the interrupt-on-completion flag both set and clear, which shows whether the interrupt follows the latched command or a stale one. Reads cover words and every byte lane, each mapped region and unmapped offsets, and rely on a shadow model that updates every clock. Polling sequences with a late completion show that the status reflects the state before each read edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W    = 32;
  localparam int CMD_OFS   = 'h00;
  localparam int STAT_OFS  = 'h04;
  localparam int WBUF_BASE = 'h80;
  localparam int RBUF_BASE = 'h90;

  typedef struct packed {
    logic [7:0] size;
    logic [3:0] sub;
    logic       ioc;
    logic [7:0] code;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_cmd(input logic [WORD_W-1:0] w);
    cmd_fields_t c;
    c.code = w[7:0];
    c.ioc  = w[8];
    c.sub  = w[15:12];
    c.size = w[23:16];
    return c;
  endfunction
endpackage

// File: rtl/mbx_cmd_stat.sv
module mbx_cmd_stat
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [7:0]        initiator,
  input  logic              done,
  input  logic              done_err,
  input  logic [7:0]        done_code,
  output logic              busy,
  output logic              doorbell,
  output cmd_fields_t       cmd,
  output logic [7:0]        init_id,
  output logic              irq,
  output logic              overrun,
  output logic [WORD_W-1:0] status_word
);
  logic        busy_q, err_q, db_q, irq_q, ovr_q;
  logic [7:0]  code_q, init_q;
  cmd_fields_t cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      db_q   <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      code_q <= '0;
      init_q <= '0;
      cmd_q  <= '0;
    end else begin
      db_q  <= 1'b0;
      irq_q <= 1'b0;
      if (done && busy_q) begin
        busy_q <= 1'b0;
        err_q  <= done_err;
        code_q <= done_code;
        irq_q  <= cmd_q.ioc;
      end
      if (cmd_wr) begin
        if (busy_q) begin
          ovr_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          db_q   <= 1'b1;
          cmd_q  <= unpack_cmd(wdata);
          init_q <= initiator;
          err_q  <= 1'b0;
          code_q <= '0;
        end
      end
    end
  end

  assign busy        = busy_q;
  assign doorbell    = db_q;
  assign cmd         = cmd_q;
  assign init_id     = init_q;
  assign irq         = irq_q;
  assign overrun     = ovr_q;
  assign status_word = {8'h00, code_q, init_q, cmd_q.sub, 2'b00, err_q, busy_q};
endmodule

// File: rtl/mbx_wbuf.sv
module mbx_wbuf
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORDS*WORD_W-1:0] flat
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        word_q <= wdata;
    end
    assign flat[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [IDX_W-1:0]  ctl_idx,
  input  logic [WORD_W-1:0] ctl_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[i] <= '0;
      else if (ctl_we && (ctl_idx == IDX_W'(i)))
        words[i] <= ctl_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < WORDS; i++)
      if (rd_idx == IDX_W'(i)) rd_word = words[i];
  end
endmodule

// File: rtl/host_ctl_mailbox.sv
module host_ctl_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WBUF_WORDS = 4,
  parameter int RBUF_WORDS = 4,
  localparam int WB_IDX_W  = (WBUF_WORDS > 1) ? $clog2(WBUF_WORDS) : 1,
  localparam int RB_IDX_W  = (RBUF_WORDS > 1) ? $clog2(RBUF_WORDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hst_req,
  input  logic                         hst_we,
  input  logic                         hst_byte,
  input  logic [ADDR_W-1:0]            hst_addr,
  input  logic [WORD_W-1:0]            hst_wdata,
  input  logic [7:0]                   hst_initiator,
  output logic                         hst_rvalid,
  output logic [WORD_W-1:0]            hst_rdata,
  output logic                         host_irq,
  output logic                         ctl_doorbell,
  output logic                         ctl_busy,
  output logic [7:0]                   ctl_cmd_code,
  output logic                         ctl_ioc,
  output logic [3:0]                   ctl_sub,
  output logic [7:0]                   ctl_size,
  output logic [7:0]                   ctl_initiator,
  output logic [WBUF_WORDS*WORD_W-1:0] ctl_wbuf,
  input  logic                         ctl_done,
  input  logic                         ctl_err,
  input  logic [7:0]                   ctl_err_code,
  input  logic                         ctl_rb_we,
  input  logic [RB_IDX_W-1:0]          ctl_rb_idx,
  input  logic [WORD_W-1:0]            ctl_rb_data,
  output logic                         ctl_overrun
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   wa, wb_off, rb_off;
  logic              hit_cmd, hit_stat, hit_wb, hit_rb;
  logic              cmd_wr, wb_wr, rd_req;
  logic [WORD_W-1:0] status_word, rb_word, rd_word, rd_sel;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q;
  cmd_fields_t       cmd;

  // Address decode, on word granularity
  assign wa       = hst_addr[ADDR_W-1:2];
  assign wb_off   = wa - WA_W'(WBUF_BASE / 4);
  assign rb_off   = wa - WA_W'(RBUF_BASE / 4);
  assign hit_cmd  = (wa == WA_W'(CMD_OFS / 4));
  assign hit_stat = (wa == WA_W'(STAT_OFS / 4));
  assign hit_wb   = (wa >= WA_W'(WBUF_BASE / 4)) && (wb_off < WA_W'(WBUF_WORDS));
  assign hit_rb   = (wa >= WA_W'(RBUF_BASE / 4)) && (rb_off < WA_W'(RBUF_WORDS));

  assign cmd_wr = hst_req && hst_we && hit_cmd;
  assign wb_wr  = hst_req && hst_we && hit_wb && !ctl_busy;
  assign rd_req = hst_req && !hst_we;

  mbx_cmd_stat u_cs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .wdata       (hst_wdata),
    .initiator   (hst_initiator),
    .done        (ctl_done),
    .done_err    (ctl_err),
    .done_code   (ctl_err_code),
    .busy        (ctl_busy),
    .doorbell    (ctl_doorbell),
    .cmd         (cmd),
    .init_id     (ctl_initiator),
    .irq         (host_irq),
    .overrun     (ctl_overrun),
    .status_word (status_word)
  );

  mbx_wbuf #(.WORDS(WBUF_WORDS)) u_wb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wb_wr),
    .wr_idx (wb_off[WB_IDX_W-1:0]),
    .wdata  (hst_wdata),
    .flat   (ctl_wbuf)
  );

  mbx_rbuf #(.WORDS(RBUF_WORDS)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_rb_we),
    .ctl_idx  (ctl_rb_idx),
    .ctl_data (ctl_rb_data),
    .rd_idx   (rb_off[RB_IDX_W-1:0]),
    .rd_word  (rb_word)
  );

  // Read mux: write-only and unmapped words return zero
  always_comb begin
    if (hit_stat)    rd_word = status_word;
    else if (hit_rb) rd_word = rb_word;
    else             rd_word = '0;
  end

  always_comb begin
    if (hst_byte) rd_sel = {24'h0, rd_word[8*hst_addr[1:0] +: 8]};
    else          rd_sel = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rd_sel;
    end
  end

  assign hst_rvalid   = rvalid_q;
  assign hst_rdata    = rdata_q;
  assign ctl_cmd_code = cmd.code;
  assign ctl_ioc      = cmd.ioc;
  assign ctl_sub      = cmd.sub;
  assign ctl_size     = cmd.size;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_wr,
  input logic busy,
  input logic doorbell,
  input logic done,
  input logic ioc,
  input logic irq,
  input logic overrun
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy |=> busy && doorbell);
  p_doorbell_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> !busy);
  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy |=> overrun);
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_irq_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done && ioc |=> irq);
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done && ioc) |=> !irq);
  p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && done && !cmd_wr |=> !busy);
endmodule

bind host_ctl_mailbox mbx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .busy     (ctl_busy),
  .doorbell (ctl_doorbell),
  .done     (ctl_done),
  .ioc      (ctl_ioc),
  .irq      (host_irq),
  .overrun  (ctl_overrun)
);

// File: tb/sim_host_ctl_mailbox.sv
`timescale 1ns/1ps
module sim_host_ctl_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 0, hst_we = 0, hst_byte = 0;
  logic [7:0]  hst_addr = 0;
  logic [31:0] hst_wdata = 0;
  logic [7:0]  hst_initiator = 0;
  logic        hst_rvalid, host_irq, ctl_doorbell, ctl_busy, ctl_ioc, ctl_overrun;
  logic [31:0] hst_rdata;
  logic [7:0]  ctl_cmd_code, ctl_size, ctl_initiator;
  logic [3:0]  ctl_sub;
  logic [127:0] ctl_wbuf;
  logic        ctl_done = 0, ctl_err = 0, ctl_rb_we = 0;
  logic [7:0]  ctl_err_code = 0;
  logic [1:0]  ctl_rb_idx = 0;
  logic [31:0] ctl_rb_data = 0;

  always #4 clk = ~clk;

  host_ctl_mailbox u0 (.*);

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  bit          m_busy, m_err, m_db, m_irq, m_ovr, m_rv;
  logic [7:0]  m_code, m_init;
  logic [31:0] m_cmd, m_rdata;
  logic [31:0] m_wb [4];
  logic [31:0] m_rb [4];
  string       m_rtag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_db = 0; m_irq = 0; m_ovr = 0; m_rv = 0;
      m_code = 0; m_init = 0; m_cmd = 0; m_rdata = 0; m_rtag = "R10";
      for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
    end else begin
      automatic bit ob = m_busy;
      automatic logic [31:0] w = 0;
      automatic int a = int'(hst_addr);
      m_rv = 0;
      if (hst_req && !hst_we) begin
        m_rv = 1;
        if (a >= 4 && a < 8) begin
          w = {8'h00, m_code, m_init, m_cmd[15:12], 2'b00, m_err, m_busy};
          m_rtag = "R4";
        end else if (a >= 'h90 && a < 'ha0) begin
          w = m_rb[(a - 'h90) / 4];
          m_rtag = "R8";
        end else begin
          w = 0;
          m_rtag = "R9";
        end
        if (hst_byte) w = (w >> (8 * (a % 4))) & 32'hFF;
        m_rdata = w;
      end
      m_db = 0; m_irq = 0;
      if (ctl_done && ob) begin
        m_busy = 0; m_err = ctl_err; m_code = ctl_err_code; m_irq = m_cmd[8];
      end
      if (hst_req && hst_we && a < 4) begin
        if (ob) m_ovr = 1;
        else begin
          m_busy = 1; m_db = 1; m_cmd = hst_wdata & 32'h00FF_F1FF;
          m_init = hst_initiator; m_err = 0; m_code = 0;
        end
      end
      if (hst_req && hst_we && a >= 'h80 && a < 'h90 && !ob)
        m_wb[(a - 'h80) / 4] = hst_wdata;
      if (ctl_rb_we) m_rb[ctl_rb_idx] = ctl_rb_data;
    end
  end

  task automatic cmp(string tag, string what, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge; all outputs are registered
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp("R3", "busy", 128'(ctl_busy), 128'(m_busy));
      cmp("R2", "doorbell", 128'(ctl_doorbell), 128'(m_db));
      cmp("R6", "irq", 128'(host_irq), 128'(m_irq));
      cmp("R5", "overrun", 128'(ctl_overrun), 128'(m_ovr));
      cmp("R10", "rvalid", 128'(hst_rvalid), 128'(m_rv));
      if (m_rv) cmp(m_rtag, "rdata", 128'(hst_rdata), 128'(m_rdata));
      cmp("R2", "fields", 128'({ctl_size, ctl_sub, ctl_ioc, ctl_cmd_code, ctl_initiator}),
          128'({m_cmd[23:16], m_cmd[15:12], m_cmd[8], m_cmd[7:0], m_init}));
      cmp("R7", "wbuf", ctl_wbuf, {m_wb[3], m_wb[2], m_wb[1], m_wb[0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    hst_req = 1; hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_req = 0; hst_we = 0;
  endtask

  task automatic hr(input logic [7:0] a, input bit b, output logic [31:0] d);
    hst_req = 1; hst_we = 0; hst_addr = a; hst_byte = b;
    @(negedge clk);
    hst_req = 0; hst_byte = 0;
    d = hst_rdata;
  endtask

  task automatic expect_rd(string tag, input logic [7:0] a, input bit b, input logic [31:0] e);
    logic [31:0] d;
    hr(a, b, d);
    cmp(tag, "explicit read", 128'(d), 128'(e));
  endtask

  task automatic done(input bit e, input logic [7:0] c);
    ctl_done = 1; ctl_err = e; ctl_err_code = c;
    @(negedge clk);
    ctl_done = 0; ctl_err = 0; ctl_err_code = 0;
  endtask

  task automatic rbw(input logic [1:0] i, input logic [31:0] d);
    ctl_rb_we = 1; ctl_rb_idx = i; ctl_rb_data = d;
    @(negedge clk);
    ctl_rb_we = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state visible at the ports
    expect_rd("R1", 8'h04, 0, 32'h0);
    expect_rd("R1", 8'h9C, 0, 32'h0);
    cmp("R1", "overrun after reset", 128'(ctl_overrun), 128'(0));

    // R7: load payload, R2: command with ioc, sub 0xA, size 3
    hst_initiator = 8'h5C;
    hw(8'h80, 32'hDEAD_0001);
    hw(8'h84, 32'hCAFE_0002);
    hw(8'h8C, 32'h1234_5678);
    hw(8'h00, 32'hFF03_A1F0);
    cmp("R2", "doorbell after command", 128'(ctl_doorbell), 128'(1));
    // R4: busy, initiator, sub id in status
    expect_rd("R4", 8'h04, 0, 32'h0000_5CA1);
    // R5: write while busy dropped, wbuf protected
    hw(8'h00, 32'h0000_2011);
    hw(8'h80, 32'h0BAD_0BAD);
    cmp("R5", "overrun set", 128'(ctl_overrun), 128'(1));
    cmp("R5", "wbuf word0 kept", 128'(ctl_wbuf[31:0]), 128'(32'hDEAD_0001));
    // R9: writes to status and read buffer have no effect
    hw(8'h04, 32'hFFFF_FFFF);
    hw(8'h90, 32'hFFFF_FFFF);
    expect_rd("R9", 8'h90, 0, 32'h0);
    // R8: controller fills the read buffer
    rbw(2'd0, 32'hA1B2_C3D4);
    rbw(2'd3, 32'h0102_0304);
    for (int k = 0; k < 4; k++)
      expect_rd("R8", 8'h90 + 8'(k), 1, 32'(8'(32'hA1B2_C3D4 >> (8 * k))));
    expect_rd("R8", 8'h9C, 0, 32'h0102_0304);
    // R3: polling, then completion with error
    for (int p = 0; p < 3; p++) hr(8'h04, 0, d);
    cmp("R3", "still busy while polling", 128'(d[0]), 128'(1));
    done(1, 8'h3E);
    cmp("R6", "irq after done with ioc", 128'(host_irq), 128'(1));
    expect_rd("R3", 8'h04, 0, 32'h003E_5CA2);
    // R11: idle done ignored
    done(0, 8'h77);
    expect_rd("R11", 8'h04, 0, 32'h003E_5CA2);
    cmp("R11", "no irq on idle done", 128'(host_irq), 128'(0));
    // R9: write-only and unmapped reads
    expect_rd("R9", 8'h00, 0, 32'h0);
    expect_rd("R9", 8'h84, 0, 32'h0);
    expect_rd("R9", 8'h40, 0, 32'h0);
    // second command without ioc; done in same cycle as a write
    hst_initiator = 8'h21;
    hw(8'h00, 32'h0001_30EF);
    expect_rd("R3", 8'h04, 0, 32'h0000_2131);
    ctl_done = 1; hst_req = 1; hst_we = 1; hst_addr = 8'h00; hst_wdata = 32'h0000_4099;
    @(negedge clk);
    ctl_done = 0; hst_req = 0; hst_we = 0;
    cmp("R6", "no irq without ioc", 128'(host_irq), 128'(0));
    cmp("R3", "busy cleared by done", 128'(ctl_busy), 128'(0));
    // accepted write after the simultaneous case
    hw(8'h88, 32'h5555_AAAA);
    hw(8'h00, 32'h0002_4199);
    cmp("R2", "sub field", 128'(ctl_sub), 128'(4));
    cmp("R7", "wbuf word2", 128'(ctl_wbuf[95:64]), 128'(32'h5555_AAAA));
    for (int p = 0; p < 8 && ctl_busy; p++) begin
      if (p == 4) done(0, 8'h00); else hr(8'h04, 0, d);
    end
    cmp("R6", "status clean", 128'(ctl_busy), 128'(0));
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule